// File: doc/BRIEF.md
# Grouped Double-Buffered Compare Timer

This block is the counting and compare core of a seven-channel timer. A counter advances on each clock cycle in which the `tick` enable is high. It runs either as a plain up-counter that wraps at a selectable maximum, or in a triangle mode that climbs to the maximum and then falls back to zero. The maximum comes from a length selector: 16, 12, 10 or 8 bits. When the counter wraps, a sticky overflow flag is set, and `irq_en` masks the interrupt request derived from that flag.

Software never writes a channel's active compare value directly. Each channel holds a staging (shadow) register, and the active latch copies that register only when the channel's load event occurs. A channel's load event is one of four: every cycle (so a write shows up at once), the counter sitting at zero, a turning point of triangle counting, or the counter equal to channel 0's active value. Channels 1 to 6 can be tied into groups. The lowest-numbered member of a group decides the event, and all members load on that same edge, so related duty cycles change together. Each channel raises a one-tick match strobe when the counter equals its active value.

Top module: `grp_cmp_timer`

## Requirements
- R1: While `rst_n` is low and after its release, `count`, every active latch, `match` and `ovf_flag` are zero.
- R2: `len_sel` picks the counter maximum: 0 gives 0xFFFF, 1 gives 0x0FFF, 2 gives 0x03FF and 3 gives 0x00FF. With `updown` low, each tick adds one and a tick at the maximum returns to 0. Without a tick, the count holds.
- R3: With `updown` high, the counter counts up to the maximum, then down to 0, then up again. A tick at the maximum gives maximum-1, and a tick at 0 while falling gives 1.
- R4: `clr` forces the count to 0 and the direction to rising on the next edge, overriding `tick`.
- R5: `ovf_flag` is set by a tick at the maximum in up mode, or by a tick from 1 to 0 while falling in triangle mode. It stays set until `flag_clr` is high on an edge without a new set (a set wins). `irq` equals `ovf_flag & irq_en`.
- R6: Each channel has a load source in `ld_src[2i+1:2i]`. 0 loads the active latch on every edge. 1 loads on a tick at count 0. 2 loads on a tick at a turning point (rising at the maximum or falling at 0, triangle mode only). 3 loads on a tick where the count equals channel 0's active value. Load events are suppressed while `clr` is high.
- R7: A shadow write on the same edge as a load event moves the newly written value into the active latch. With source 0, the written value appears on `active` one edge after the write.
- R8: `grp_sel` 0 keeps channels 1 to 6 independent. 1 forms groups {1,2}, {3,4} and {5,6}. 2 forms {1,2,3} and {4,5,6}. 3 forms {1..6}. Every member of a group loads when the group's lowest channel, using its own source, fires.
- R9: Channel 0 always forms its own group and follows only its own load source.
- R10: `match[i]` is high exactly in a cycle with `tick` high and `count` equal to channel i's active value.
- R11: A change of `len_sel` at once zeroes the count bits above the new length. The next tick continues from that truncated value within the new maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count enable for this cycle |
| clr | input | 1 | Counter clear strobe |
| len_sel | input | 2 | Counter length select |
| updown | input | 1 | 1 = triangle counting, 0 = wrap counting |
| grp_sel | input | 2 | Channel grouping select |
| ld_src | input | 2*NCH | Per-channel latch load source |
| wr_en | input | NCH | Per-channel shadow write strobe |
| wr_data | input | 16*NCH | Per-channel shadow write data |
| flag_clr | input | 1 | Clears the overflow flag |
| irq_en | input | 1 | Interrupt enable |
| count | output | 16 | Counter value, masked to the selected length |
| active | output | 16*NCH | Active compare latches |
| match | output | NCH | Per-channel compare match strobes |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Gated overflow interrupt request |

## Verification
The properties check, on every cycle, the local counter steps: the clear, the hold without a tick, the wrap at the maximum, the reversal at the top in triangle mode, the stickiness of the overflow flag, and the one-edge path of an immediate-load write on channel 0. The effect of grouping, the load events of each channel and their coincidence with writes depend on long histories of counter values and shadow contents. Only the bench's sweeps show these, comparing every active latch and every match against an arithmetic model over all group codes, all load sources and both counting modes. Wrap at 12 bits, length changes in mid-count and writes that land on zero-count events are shown by directed runs.

// File: rtl/gct_pkg.sv
package gct_pkg;
  localparam int unsigned CNT_W = 16;
  typedef logic [CNT_W-1:0] cnt_t;

  typedef enum logic [1:0] {
    LD_ON_WRITE = 2'd0,
    LD_AT_ZERO  = 2'd1,
    LD_AT_TURN  = 2'd2,
    LD_AT_CH0   = 2'd3
  } ld_src_e;

  // counter maximum for each length code (16/12/10/8 bits)
  function automatic cnt_t len_mask(input logic [1:0] sel);
    case (sel)
      2'd0:    return {CNT_W{1'b1}};
      2'd1:    return {CNT_W{1'b1}} >> 4;
      2'd2:    return {CNT_W{1'b1}} >> 6;
      default: return {CNT_W{1'b1}} >> 8;
    endcase
  endfunction

  // lowest channel of the group a channel belongs to
  function automatic int unsigned group_leader(input int unsigned ch,
                                               input logic [1:0]  grp,
                                               input int unsigned nch);
    int unsigned half;
    half = (nch - 1) / 2;
    if (ch == 0) return 0;
    case (grp)
      2'd0:    return ch;
      2'd1:    return ((ch - 1) / 2) * 2 + 1;
      2'd2:    return (ch <= half) ? 1 : half + 1;
      default: return 1;
    endcase
  endfunction
endpackage

// File: rtl/gct_counter.sv
module gct_counter
  import gct_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       clr,
  input  logic       updown,
  input  logic [1:0] len_sel,
  output cnt_t       count,
  output logic       at_zero,
  output logic       at_turn,
  output logic       wrap
);
  cnt_t mask, m, cnt_q, cnt_d;
  logic up_q, up_d, live;

  always_comb begin
    mask  = len_mask(len_sel);
    m     = cnt_q & mask;
    cnt_d = m;
    up_d  = up_q;
    if (clr) begin
      cnt_d = '0;
      up_d  = 1'b1;
    end else if (tick) begin
      if (!updown) begin
        up_d  = 1'b1;
        cnt_d = (m == mask) ? '0 : m + 1'b1;
      end else if (up_q) begin
        if (m == mask) begin
          cnt_d = m - 1'b1;
          up_d  = 1'b0;
        end else begin
          cnt_d = m + 1'b1;
        end
      end else begin
        if (m == '0) begin
          cnt_d = cnt_t'(1);
          up_d  = 1'b1;
        end else begin
          cnt_d = m - 1'b1;
        end
      end
    end
  end

  always_comb begin
    live    = tick & ~clr;
    at_zero = live && (m == '0);
    at_turn = live && updown && (up_q ? (m == mask) : (m == '0));
    wrap    = live && (updown ? (!up_q && m == cnt_t'(1)) : (m == mask));
    count   = m;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      up_q  <= up_d;
    end
  end
endmodule

// File: rtl/gct_load_ctrl.sv
module gct_load_ctrl
  import gct_pkg::*;
#(
  parameter int unsigned NCH = 7
) (
  input  logic [2*NCH-1:0] ld_src,
  input  logic [1:0]       grp_sel,
  input  logic             at_zero,
  input  logic             at_turn,
  input  logic             at_ch0,
  output logic [NCH-1:0]   fire
);
  localparam int unsigned IW = (NCH > 1) ? $clog2(NCH) : 1;

  logic [NCH-1:0] own;

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      case (ld_src_e'(ld_src[2*i +: 2]))
        LD_ON_WRITE: own[i] = 1'b1;
        LD_AT_ZERO:  own[i] = at_zero;
        LD_AT_TURN:  own[i] = at_turn;
        default:     own[i] = at_ch0;
      endcase
    end
    for (int i = 0; i < NCH; i++) begin
      fire[i] = own[IW'(group_leader(i, grp_sel, NCH))];
    end
  end
endmodule

// File: rtl/gct_channel.sv
module gct_channel
  import gct_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic wr_en,
  input  cnt_t wr_data,
  input  logic fire,
  input  cnt_t count,
  output cnt_t active,
  output logic match
);
  cnt_t sh_q, sh_d, act_q, act_d;

  always_comb begin
    sh_d   = wr_en ? wr_data : sh_q;
    act_d  = fire ? sh_d : act_q;
    active = act_q;
    match  = tick && (count == act_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      act_q <= '0;
    end else begin
      sh_q  <= sh_d;
      act_q <= act_d;
    end
  end
endmodule

// File: rtl/grp_cmp_timer.sv
module grp_cmp_timer
  import gct_pkg::*;
#(
  parameter int unsigned NCH = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 clr,
  input  logic [1:0]           len_sel,
  input  logic                 updown,
  input  logic [1:0]           grp_sel,
  input  logic [2*NCH-1:0]     ld_src,
  input  logic [NCH-1:0]       wr_en,
  input  logic [CNT_W*NCH-1:0] wr_data,
  input  logic                 flag_clr,
  input  logic                 irq_en,
  output logic [CNT_W-1:0]     count,
  output logic [CNT_W*NCH-1:0] active,
  output logic [NCH-1:0]       match,
  output logic                 ovf_flag,
  output logic                 irq
);
  logic           at_zero, at_turn, wrap, at_ch0;
  logic [NCH-1:0] fire;
  logic           flag_q, flag_d;

  gct_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .clr(clr), .updown(updown),
    .len_sel(len_sel), .count(count), .at_zero(at_zero),
    .at_turn(at_turn), .wrap(wrap)
  );

  always_comb at_ch0 = match[0] & ~clr;

  gct_load_ctrl #(.NCH(NCH)) u_ld (
    .ld_src(ld_src), .grp_sel(grp_sel), .at_zero(at_zero),
    .at_turn(at_turn), .at_ch0(at_ch0), .fire(fire)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    gct_channel u_ch (
      .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en[i]),
      .wr_data(wr_data[i*CNT_W +: CNT_W]), .fire(fire[i]), .count(count),
      .active(active[i*CNT_W +: CNT_W]), .match(match[i])
    );
  end

  always_comb begin
    flag_d = flag_q;
    if (wrap)          flag_d = 1'b1;
    else if (flag_clr) flag_d = 1'b0;
    ovf_flag = flag_q;
    irq      = flag_q & irq_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end
endmodule

// File: rtl/gct_checker.sv
module gct_checker
  import gct_pkg::*;
#(
  parameter int unsigned NCH = 7
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 tick,
  input logic                 clr,
  input logic [1:0]           len_sel,
  input logic                 updown,
  input logic [2*NCH-1:0]     ld_src,
  input logic [NCH-1:0]       wr_en,
  input logic [CNT_W*NCH-1:0] wr_data,
  input logic                 flag_clr,
  input logic [CNT_W-1:0]     count,
  input logic [CNT_W*NCH-1:0] active,
  input logic                 ovf_flag
);
  // R4
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> count == '0);

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clr) |=> count == ($past(count) & len_mask(len_sel)));

  // R2
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clr && !updown && count == len_mask(len_sel)) |=> count == '0);

  // R3
  top_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clr && updown && count == len_mask(len_sel))
      |=> count == (($past(count) - 1'b1) & len_mask(len_sel)));

  // R5
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clr && !updown && count == len_mask(len_sel)) |=> ovf_flag);

  // R5
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !flag_clr) |=> ovf_flag);

  // R7
  imm_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en[0] && ld_src[1:0] == 2'd0)
      |=> active[CNT_W-1:0] == $past(wr_data[CNT_W-1:0]));
endmodule

bind grp_cmp_timer gct_checker #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .clr(clr), .len_sel(len_sel),
  .updown(updown), .ld_src(ld_src), .wr_en(wr_en), .wr_data(wr_data),
  .flag_clr(flag_clr), .count(count), .active(active), .ovf_flag(ovf_flag)
);

// File: tb/grp_cmp_timer_bench.sv
module grp_cmp_timer_bench;
  import gct_pkg::*;
  localparam int NCH = 7;
  localparam int CW  = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rst_n, tick, clr, updown, flag_clr, irq_en;
  logic [1:0]        len_sel, grp_sel;
  logic [2*NCH-1:0]  ld_src;
  logic [NCH-1:0]    wr_en, match;
  logic [CW*NCH-1:0] wr_data, active;
  logic [CW-1:0]     count;
  logic              ovf_flag, irq;

  grp_cmp_timer u_grp_cmp_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .clr(clr), .len_sel(len_sel),
    .updown(updown), .grp_sel(grp_sel), .ld_src(ld_src), .wr_en(wr_en),
    .wr_data(wr_data), .flag_clr(flag_clr), .irq_en(irq_en), .count(count),
    .active(active), .match(match), .ovf_flag(ovf_flag), .irq(irq)
  );

  // staged stimulus, applied at the falling edge
  logic              s_tick, s_clr, s_updown, s_flag_clr, s_irq_en;
  logic [1:0]        s_len, s_grp;
  logic [2*NCH-1:0]  s_src;
  logic [NCH-1:0]    s_wr;
  logic [CW*NCH-1:0] s_data;

  // reference model state
  logic [CW-1:0] mcnt;
  logic          mup, mflag;
  logic [CW-1:0] msh  [NCH];
  logic [CW-1:0] mact [NCH];

  int    checks = 0;
  int    errors = 0;
  string ptag   = "";
  logic [31:0] lf = 32'h1234_5678;

  function automatic logic [31:0] rnd_next(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  function automatic logic [CW-1:0] max_of(input logic [1:0] s);
    case (s)
      2'd0: return 16'hFFFF;
      2'd1: return 16'h0FFF;
      2'd2: return 16'h03FF;
      default: return 16'h00FF;
    endcase
  endfunction

  function automatic int lead(input int ch, input logic [1:0] g);
    if (ch == 0) return 0;
    case (g)
      2'd0: return ch;
      2'd1: return (ch % 2 == 1) ? ch : ch - 1;
      2'd2: return (ch < 4) ? 1 : 4;
      default: return 1;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    mcnt = '0; mup = 1'b1; mflag = 1'b0;
    for (int i = 0; i < NCH; i++) begin msh[i] = '0; mact[i] = '0; end
  endtask

  task automatic cycle();
    logic [CW-1:0] mk, m;
    logic          live, z, tn, e0, wr;
    logic [NCH-1:0] own, mexp;
    logic [CW-1:0] nsh [NCH];
    string t;
    @(negedge clk);
    tick = s_tick; clr = s_clr; updown = s_updown; flag_clr = s_flag_clr;
    irq_en = s_irq_en; len_sel = s_len; grp_sel = s_grp; ld_src = s_src;
    wr_en = s_wr; wr_data = s_data;
    #2;
    mk = max_of(len_sel);
    m  = mcnt & mk;
    t  = (ptag != "") ? ptag : (updown ? "R3" : "R2");
    chk(t, count, m);
    for (int i = 0; i < NCH; i++) begin
      t = (ptag != "") ? ptag : ((i == 0) ? "R9" : ((grp_sel != 0) ? "R8" : "R6"));
      chk(t, active[i*CW +: CW], mact[i]);
      mexp[i] = tick && (m == mact[i]);
    end
    chk("R10", match, mexp);
    chk("R5", ovf_flag, mflag);
    chk("R5", irq, mflag & irq_en);
    // next state
    live = tick && !clr;
    z  = live && (m == 0);
    tn = live && updown && (mup ? (m == mk) : (m == 0));
    e0 = live && (m == mact[0]);
    wr = live && (updown ? (!mup && m == 1) : (m == mk));
    for (int i = 0; i < NCH; i++) begin
      case (ld_src[2*i +: 2])
        2'd0: own[i] = 1'b1;
        2'd1: own[i] = z;
        2'd2: own[i] = tn;
        default: own[i] = e0;
      endcase
      nsh[i] = wr_en[i] ? wr_data[i*CW +: CW] : msh[i];
    end
    for (int i = 0; i < NCH; i++) begin
      if (own[lead(i, grp_sel)]) mact[i] = nsh[i];
      msh[i] = nsh[i];
    end
    if (wr) mflag = 1'b1;
    else if (flag_clr) mflag = 1'b0;
    if (clr) begin mcnt = 0; mup = 1'b1; end
    else if (tick) begin
      if (!updown) begin mup = 1'b1; mcnt = (m == mk) ? 16'd0 : m + 16'd1; end
      else if (mup) begin
        if (m == mk) begin mcnt = m - 16'd1; mup = 1'b0; end
        else mcnt = m + 16'd1;
      end else begin
        if (m == 0) begin mcnt = 16'd1; mup = 1'b1; end
        else mcnt = m - 16'd1;
      end
    end else mcnt = m;
  endtask

  task automatic quiet();
    s_tick = 0; s_clr = 0; s_updown = 0; s_flag_clr = 0; s_irq_en = 0;
    s_len = 0; s_grp = 0; s_src = '0; s_wr = '0; s_data = '0;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    quiet();
    rst_n = 0; tick = 0; clr = 0; updown = 0; flag_clr = 0; irq_en = 0;
    len_sel = 0; grp_sel = 0; ld_src = '0; wr_en = '0; wr_data = '0;
    model_reset();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", count, 0);
    chk("R1", active, '0);
    chk("R1", match, '0);
    chk("R1", ovf_flag, 0);
    rst_n = 1;

    // sweep: every group code, every load source mix, both count modes
    for (int g = 0; g < 4; g++) begin
      for (int s = 0; s < 4; s++) begin
        s_len    = (s == 3) ? 2'd2 : 2'd3;
        s_updown = s[0];
        s_grp    = 2'(g);
        s_irq_en = g[0];
        for (int c = 0; c < NCH; c++) s_src[2*c +: 2] = 2'((s + c) % 4);
        for (int k = 0; k < 600; k++) begin
          lf = rnd_next(lf);
          s_tick     = (lf[1:0] != 2'b00);
          s_clr      = (lf[8:2] == 7'd0);
          s_flag_clr = (lf[11:9] == 3'd0);
          lf = rnd_next(lf);
          for (int c = 0; c < NCH; c++) s_wr[c] = (lf[3*c +: 3] == 3'd0);
          for (int c = 0; c < NCH; c++) begin
            lf = rnd_next(lf);
            s_data[c*CW +: CW] = lf[15:0] & max_of(s_len);
          end
          cycle();
        end
      end
    end

    // R2: full wrap at 12 bits
    quiet(); s_len = 2'd1; s_clr = 1; cycle(); s_clr = 0; s_tick = 1;
    for (int k = 0; k < 4200; k++) cycle();

    // R11: shrink length in mid-count (300 -> 300 & 0xFF)
    ptag = "R11";
    quiet(); s_clr = 1; cycle(); s_clr = 0; s_tick = 1;
    for (int k = 0; k < 300; k++) cycle();
    s_len = 2'd3;
    for (int k = 0; k < 20; k++) cycle();

    // R4: clear while ticking
    ptag = "R4";
    quiet(); s_tick = 1; s_len = 2'd3;
    for (int k = 0; k < 200; k++) begin
      s_clr = (k % 37 == 36);
      cycle();
    end

    // R7: writes landing on zero-count load events
    ptag = "R7";
    quiet(); s_tick = 1; s_len = 2'd3;
    for (int c = 0; c < NCH; c++) s_src[2*c +: 2] = 2'd1;
    for (int k = 0; k < 600; k++) begin
      s_wr = ((mcnt & 16'h00FF) == 0) ? {NCH{1'b1}} : '0;
      for (int c = 0; c < NCH; c++) begin
        lf = rnd_next(lf);
        s_data[c*CW +: CW] = lf[15:0] & 16'h00FF;
      end
      cycle();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule